// File: doc/BRIEF.md
# BCD Calendar Clock Core

This core keeps a calendar time as seven packed-BCD bytes: seconds, minutes, hours (24-hour), day of month, month, year within a century, and weekday. A single-cycle pulse on the 1 Hz tick input moves the time forward by one second while counting is enabled. Carries ripple through the fields in the same cycle. The day wraps according to the length of the month, and February gains a 29th day in years divisible by four.

Software reaches the core through a byte-wide register port. Writes are synchronous and reads are combinational from the address. A control byte does three things. It enables counting. It requests a snapshot that copies every counting field into a static shadow set in one clock cycle. It selects whether time reads show that shadow or the live counters. New time values are loaded while counting is disabled, so a host can write the calendar one byte at a time without the clock moving between bytes.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the seven fields read seconds 00, minutes 00, hours 00, day 01, month 01, year 00, weekday 00. The control byte at offset 7 reads 00 and the status byte at offset 8 reads 00.
- R2: While control bit 0 (run) is 1, each tick pulse adds one to the seconds field in BCD. While run is 0, ticks leave every field unchanged.
- R3: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the day.
- R4: In months 04, 06, 09 and 11 the day wraps from 30 to 01. In the other months except February it wraps from 31 to 01. A wrap carries into the month.
- R5: February ends at day 28, or at day 29 when the year (00 to 99) is divisible by 4. Year 00 counts as a leap year.
- R6: Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00.
- R7: The weekday field (offset 6) counts 00 to 06 and advances by one whenever the day advances, wrapping from 06 to 00.
- R8: Writes to offsets 0 to 6 load the addressed field (0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 weekday) only while run is 0. While run is 1 they are ignored.
- R9: A write to the control byte that sets bit 6 when bit 6 was 0 copies all seven live fields into the shadow set at that clock edge. Writing bit 6 while it is already 1 takes no new copy. While control bit 7 is 1, reads of offsets 0 to 6 return the shadow set.
- R10: While control bit 7 is 0, reads of offsets 0 to 6 return the live fields.
- R11: The control byte reads back exactly as written, including bits 1 to 5. Those bits have no effect on counting. Status bit 1 is 1 exactly when run is 1, and the other status bits read 0.
- R12: A snapshot requested in the same cycle as a counting tick captures the time as it was before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick1Hz | input | 1 | One-cycle pulse once per second |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W (4) | Register offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |

## Verification
The bench loads times that sit one second before each kind of rollover. It covers the full carry from 23:59:59 on 31 December of year 99 to a new century, the end of a 30-day month, and February in a common year, in a leap year and in year 00. A wrong month-length table or leap test would show a 29th or 31st day where 01 belongs, and a broken carry would leave a higher field unchanged. The snapshot tests re-set the request bit without clearing it first, and they request a copy in the same cycle as a tick. A level-triggered capture would overwrite the shadow with later time, and capturing after the increment would read one second late. Writes made while running, and ticks made while stopped, must leave the read-back time untouched.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int BYTE_W   = 8;
  localparam int FIELD_N  = 7;
  localparam int SEL_W    = $clog2(FIELD_N);

  // field offsets; weekday last, its position is decoded by software
  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_DAY  = 3;
  localparam int FLD_MON  = 4;
  localparam int FLD_YEAR = 5;
  localparam int FLD_WDAY = 6;

  localparam int CTRL_OFS = 7;
  localparam int STAT_OFS = 8;

  localparam int RUN_BIT      = 0;
  localparam int SNAP_BIT     = 6;
  localparam int SHADOW_BIT   = 7;
  localparam int STAT_RUN_BIT = 1;

  typedef struct packed {
    logic              countEn;
    logic              snapTake;
    logic              fieldWr;
    logic [SEL_W-1:0]  fieldSel;
    logic [BYTE_W-1:0] wrByte;
    logic              readShadow;
  } rtcStrobe_t;

  function automatic logic [BYTE_W-1:0] bcdInc(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic isLeap(input logic [BYTE_W-1:0] y);
    logic [BYTE_W-1:0] bin;
    bin = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
    return (bin[1:0] == 2'b00);
  endfunction

  function automatic logic [BYTE_W-1:0] lastDay(input logic [BYTE_W-1:0] m,
                                                input logic [BYTE_W-1:0] y);
    case (m)
      8'h02:                      return isLeap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick1Hz,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output rtcStrobe_t        strobe,
  output logic [BYTE_W-1:0] ctrlQ,
  output logic [BYTE_W-1:0] regRd,
  output logic              isTimeAddr
);

  logic ctrlHit;
  logic statHit;
  logic [BYTE_W-1:0] statusByte;

  assign ctrlHit    = (addr == ADDR_W'(CTRL_OFS));
  assign statHit    = (addr == ADDR_W'(STAT_OFS));
  assign isTimeAddr = (addr < ADDR_W'(FIELD_N));

  always_ff @(posedge clk) begin
    if (!rst_n)               ctrlQ <= '0;
    else if (wrEn && ctrlHit) ctrlQ <= wrData;
  end

  always_comb begin
    statusByte               = '0;
    statusByte[STAT_RUN_BIT] = ctrlQ[RUN_BIT];
  end

  always_comb begin
    strobe.countEn    = tick1Hz && ctrlQ[RUN_BIT];
    strobe.snapTake   = wrEn && ctrlHit && wrData[SNAP_BIT] && !ctrlQ[SNAP_BIT];
    strobe.fieldWr    = wrEn && isTimeAddr && !ctrlQ[RUN_BIT];
    strobe.fieldSel   = addr[SEL_W-1:0];
    strobe.wrByte     = wrData;
    strobe.readShadow = ctrlQ[SHADOW_BIT];
  end

  always_comb begin
    if (ctrlHit)      regRd = ctrlQ;
    else if (statHit) regRd = statusByte;
    else              regRd = '0;
  end

endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  rtcStrobe_t                strobe,
  input  logic [SEL_W-1:0]          rdSel,
  output logic [BYTE_W-1:0]         timeRd,
  output logic [FIELD_N*BYTE_W-1:0] liveFlat,
  output logic [FIELD_N*BYTE_W-1:0] shadowFlat
);

  logic [BYTE_W-1:0] liveQ   [FIELD_N];
  logic [BYTE_W-1:0] shadowQ [FIELD_N];
  logic [BYTE_W-1:0] nextQ   [FIELD_N];

  logic secEnd, minEnd, hourEnd, dayEnd, monEnd, yearEnd;
  logic minStep, hourStep, dayStep, monStep, yearStep;

  always_comb begin
    secEnd  = (liveQ[FLD_SEC]  == 8'h59);
    minEnd  = (liveQ[FLD_MIN]  == 8'h59);
    hourEnd = (liveQ[FLD_HOUR] == 8'h23);
    dayEnd  = (liveQ[FLD_DAY]  == lastDay(liveQ[FLD_MON], liveQ[FLD_YEAR]));
    monEnd  = (liveQ[FLD_MON]  == 8'h12);
    yearEnd = (liveQ[FLD_YEAR] == 8'h99);

    minStep  = secEnd;
    hourStep = minStep  && minEnd;
    dayStep  = hourStep && hourEnd;
    monStep  = dayStep  && dayEnd;
    yearStep = monStep  && monEnd;

    for (int i = 0; i < FIELD_N; i++) nextQ[i] = liveQ[i];

    nextQ[FLD_SEC] = secEnd ? 8'h00 : bcdInc(liveQ[FLD_SEC]);
    if (minStep)  nextQ[FLD_MIN]  = minEnd  ? 8'h00 : bcdInc(liveQ[FLD_MIN]);
    if (hourStep) nextQ[FLD_HOUR] = hourEnd ? 8'h00 : bcdInc(liveQ[FLD_HOUR]);
    if (dayStep) begin
      nextQ[FLD_DAY]  = dayEnd ? 8'h01 : bcdInc(liveQ[FLD_DAY]);
      nextQ[FLD_WDAY] = (liveQ[FLD_WDAY] >= 8'h06) ? 8'h00 : liveQ[FLD_WDAY] + 8'h01;
    end
    if (monStep)  nextQ[FLD_MON]  = monEnd  ? 8'h01 : bcdInc(liveQ[FLD_MON]);
    if (yearStep) nextQ[FLD_YEAR] = yearEnd ? 8'h00 : bcdInc(liveQ[FLD_YEAR]);
  end

  for (genvar g = 0; g < FIELD_N; g++) begin : gField
    localparam logic [BYTE_W-1:0] RST_V =
      (g == FLD_DAY || g == FLD_MON) ? 8'h01 : 8'h00;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        liveQ[g] <= RST_V;
      end else if (strobe.fieldWr && strobe.fieldSel == SEL_W'(g)) begin
        liveQ[g] <= strobe.wrByte;
      end else if (strobe.countEn) begin
        liveQ[g] <= nextQ[g];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)               shadowQ[g] <= RST_V;
      else if (strobe.snapTake) shadowQ[g] <= liveQ[g];
    end

    assign liveFlat[g*BYTE_W +: BYTE_W]   = liveQ[g];
    assign shadowFlat[g*BYTE_W +: BYTE_W] = shadowQ[g];
  end

  always_comb begin
    if (rdSel >= SEL_W'(FIELD_N)) timeRd = '0;
    else if (strobe.readShadow)   timeRd = shadowQ[rdSel];
    else                          timeRd = liveQ[rdSel];
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick1Hz,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);

  rtcStrobe_t                strobe;
  logic [BYTE_W-1:0]         ctrlQ;
  logic [BYTE_W-1:0]         regRd;
  logic [BYTE_W-1:0]         timeRd;
  logic                      isTimeAddr;
  logic [FIELD_N*BYTE_W-1:0] liveFlat;
  logic [FIELD_N*BYTE_W-1:0] shadowFlat;

  rtc_cal_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick1Hz   (tick1Hz),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .strobe    (strobe),
    .ctrlQ     (ctrlQ),
    .regRd     (regRd),
    .isTimeAddr(isTimeAddr)
  );

  rtc_cal_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .rdSel     (addr[SEL_W-1:0]),
    .timeRd    (timeRd),
    .liveFlat  (liveFlat),
    .shadowFlat(shadowFlat)
  );

  assign rdData = isTimeAddr ? timeRd : regRd;

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick1Hz,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic              wrSnap,
  input logic              rdRun,
  input logic              runQ,
  input logic              snapQ,
  input logic [55:0]       liveFlat,
  input logic [55:0]       shadowFlat
);

  logic snapEdge;
  logic timeWrite;
  assign snapEdge  = wrEn && (addr == ADDR_W'(7)) && wrSnap && !snapQ;
  assign timeWrite = wrEn && (addr < ADDR_W'(7));

  // R2: stopped clock only changes through a field write
  a_r2_stopped_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!runQ && !timeWrite) |=> $stable(liveFlat));

  // R2: every counting tick changes the seconds byte
  a_r2_tick_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && tick1Hz) |=> (liveFlat[7:0] != $past(liveFlat[7:0])));

  // R8: running clock ignores writes between ticks
  a_r8_run_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && !tick1Hz) |=> $stable(liveFlat));

  // R3: seconds rollover carries into minutes
  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && tick1Hz && liveFlat[7:0] == 8'h59) |=>
      (liveFlat[7:0] == 8'h00 && liveFlat[15:8] != $past(liveFlat[15:8])));

  // R9: snapshot copies the pre-edge live set
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    snapEdge |=> (shadowFlat == $past(liveFlat)));

  // R9: shadow holds without a fresh request
  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snapEdge |=> $stable(shadowFlat));

  // R11: status run flag follows the control run bit
  a_r11_status_run: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(8)) |-> (rdRun == runQ));

endmodule

bind rtc_calendar rtc_cal_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick1Hz   (tick1Hz),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrSnap    (wrData[6]),
  .rdRun     (rdData[1]),
  .runQ      (ctrlQ[0]),
  .snapQ     (ctrlQ[6]),
  .liveFlat  (liveFlat),
  .shadowFlat(shadowFlat)
);

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick1Hz = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_calendar #(.ADDR_W(4)) i_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .tick1Hz(tick1Hz), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input int a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = 4'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expectReg(input string tag, input int a, input logic [7:0] exp);
    @(negedge clk);
    addr = 4'(a);
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic tickOnce();
    @(negedge clk); tick1Hz = 1'b1;
    @(negedge clk); tick1Hz = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] s, mi, h, d, mo, y, w);
    wrReg(7, 8'h00);
    wrReg(0, s); wrReg(1, mi); wrReg(2, h); wrReg(3, d);
    wrReg(4, mo); wrReg(5, y); wrReg(6, w);
  endtask

  task automatic expectTime(input string tag, input logic [7:0] s, mi, h, d, mo, y, w);
    expectReg({tag, " sec"}, 0, s);
    expectReg({tag, " min"}, 1, mi);
    expectReg({tag, " hour"}, 2, h);
    expectReg({tag, " day"}, 3, d);
    expectReg({tag, " month"}, 4, mo);
    expectReg({tag, " year"}, 5, y);
    expectReg({tag, " wday"}, 6, w);
  endtask

  task automatic testReset();
    expectTime("R1 reset", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
    expectReg("R1 ctrl", 7, 8'h00);
    expectReg("R1 status", 8, 8'h00);
  endtask

  task automatic testTickAndStop();
    wrReg(7, 8'h01);
    repeat (3) tickOnce();
    expectReg("R2 three ticks", 0, 8'h03);
    wrReg(7, 8'h00);
    tickOnce();
    expectReg("R2 stopped tick", 0, 8'h03);
  endtask

  task automatic testWriteGate();
    wrReg(7, 8'h01);
    wrReg(0, 8'h45);
    expectReg("R8 write while running", 0, 8'h03);
    wrReg(7, 8'h00);
    wrReg(0, 8'h45);
    expectReg("R8 write while stopped", 0, 8'h45);
  endtask

  task automatic testCentury();
    setTime(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h06);
    wrReg(7, 8'h01);
    tickOnce();
    expectTime("R3 R6 R7 century", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
    setTime(8'h09, 8'h59, 8'h10, 8'h15, 8'h07, 8'h42, 8'h03);
    wrReg(7, 8'h01);
    tickOnce();
    expectReg("R2 bcd digit carry", 0, 8'h10);
    expectReg("R3 no minute carry", 1, 8'h59);
  endtask

  task automatic testMonthLengths();
    setTime(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h21, 8'h02);
    wrReg(7, 8'h01);
    tickOnce();
    expectReg("R4 april end day", 3, 8'h01);
    expectReg("R4 april end month", 4, 8'h05);
    expectReg("R7 weekday step", 6, 8'h03);
    setTime(8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h21, 8'h02);
    wrReg(7, 8'h01);
    tickOnce();
    expectReg("R4 may day 31", 3, 8'h31);
    expectReg("R4 may stays", 4, 8'h05);
  endtask

  task automatic testFebruary();
    setTime(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h00);
    wrReg(7, 8'h01);
    tickOnce();
    expectReg("R5 common feb day", 3, 8'h01);
    expectReg("R5 common feb month", 4, 8'h03);
    setTime(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h00);
    wrReg(7, 8'h01);
    tickOnce();
    expectReg("R5 leap feb 29", 3, 8'h29);
    wrReg(7, 8'h00);
    wrReg(0, 8'h59); wrReg(1, 8'h59); wrReg(2, 8'h23);
    wrReg(7, 8'h01);
    tickOnce();
    expectReg("R5 leap feb end day", 3, 8'h01);
    expectReg("R5 leap feb end month", 4, 8'h03);
    setTime(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h00, 8'h00);
    wrReg(7, 8'h01);
    tickOnce();
    expectReg("R5 year 00 leap", 3, 8'h29);
  endtask

  task automatic testSnapshot();
    setTime(8'h10, 8'h05, 8'h12, 8'h11, 8'h03, 8'h30, 8'h01);
    wrReg(7, 8'h41);
    tickOnce(); tickOnce();
    wrReg(7, 8'hC1);
    expectReg("R9 shadow sec no recapture", 0, 8'h10);
    expectReg("R9 shadow min", 1, 8'h05);
    expectReg("R9 shadow day", 3, 8'h11);
    wrReg(7, 8'h01);
    expectReg("R10 live sec", 0, 8'h12);
    wrReg(7, 8'hC1);
    expectReg("R9 fresh capture", 0, 8'h12);
    tickOnce();
    expectReg("R9 shadow frozen", 0, 8'h12);
  endtask

  task automatic testCtrlBits();
    setTime(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
    wrReg(7, 8'h3F);
    expectReg("R11 ctrl readback", 7, 8'h3F);
    expectReg("R11 status running", 8, 8'h02);
    tickOnce();
    expectReg("R11 extra bits inert", 0, 8'h21);
    wrReg(7, 8'h3E);
    expectReg("R11 status stopped", 8, 8'h00);
  endtask

  task automatic testSnapWithTick();
    setTime(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
    wrReg(7, 8'h01);
    @(negedge clk);
    wrEn = 1'b1; addr = 4'd7; wrData = 8'h41; tick1Hz = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick1Hz = 1'b0;
    wrReg(7, 8'hC1);
    expectReg("R12 snapshot before tick", 0, 8'h20);
    wrReg(7, 8'h01);
    expectReg("R12 live after tick", 0, 8'h21);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testTickAndStop();
    testWriteGate();
    testCentury();
    testMonthLengths();
    testFebruary();
    testSnapshot();
    testCtrlBits();
    testSnapWithTick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule